// File: doc/BRIEF.md
# Instruction Length and Cost Decoder

This block examines the first 16-bit word of an instruction and breaks it into its fields: whether it is a basic two-operand instruction or an extended one-operand instruction, the opcode of either kind, and the 6-bit operand selectors. From that single word it also works out how many words the whole instruction occupies and how many cycles it costs, both for the normal case and for the case where a conditional test fails. Unknown extended opcodes are flagged as illegal.

The decode logic is combinational and feeds a one-entry output register. Words enter on a valid/ready input stream and decoded results leave on a valid/ready output stream. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle (`out_ready` high), so the block passes one word per cycle at full rate. While `out_valid` is high and `out_ready` is low, every output holds its value and no new word is taken. A sequencer uses the result to execute an instruction, and it uses the length to step over the next instruction when a conditional test fails.

Top module: `instr_len_decoder`

## Requirements
- R1: When in_word[3:0] is nonzero the result is basic: out_is_ext=0, out_opcode=in_word[3:0], out_sel_a=in_word[9:4], out_sel_b=in_word[15:10], out_ext_op=0.
- R2: When in_word[3:0] is zero the result is extended: out_is_ext=1, out_ext_op=in_word[9:4], out_sel_a=in_word[15:10], out_opcode=0, out_sel_b=0.
- R3: An operand selector in 0x10..0x17, 0x1e or 0x1f needs one extra word. Every other selector needs none. out_len is 1 plus the extra words of the operands present (a and b for basic, a only for extended), so it ranges from 1 to 3.
- R4: The basic base cost is 1 for opcodes 0x1, 0x9, 0xa and 0xb; 2 for 0x2, 0x3, 0x4, 0x7 and 0x8; 3 for 0x5 and 0x6; and 2 for 0xc..0xf. out_cost is the base cost plus the extra-word count.
- R5: out_is_cond is 1 exactly for basic opcodes 0xc..0xf. out_cost_fail equals out_cost+1 for those opcodes and equals out_cost for every other instruction.
- R6: Extended opcode 0x01 has out_illegal=0 and a cost of 2 plus its operand's extra word. Every other extended opcode (0x00, 0x02..0x3f) has out_illegal=1, a cost of 1 plus the operand's extra word, and the R3 length. Basic instructions never have out_illegal set.
- R7: The decoded result of an accepted word is presented with out_valid=1 starting on the cycle after acceptance. Results leave in the order the words arrived.
- R8: in_ready equals (!out_valid || out_ready). While out_valid=1 and out_ready=0, out_valid stays 1 and every output field stays stable.
- R9: While rst_n is low, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | First instruction word is offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 16 | First instruction word |
| out_valid | output | 1 | Decoded result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_is_ext | output | 1 | 1 = extended (one-operand) instruction |
| out_opcode | output | 4 | Basic opcode, 0 for extended |
| out_ext_op | output | 6 | Extended opcode, 0 for basic |
| out_sel_a | output | 6 | Operand a selector |
| out_sel_b | output | 6 | Operand b selector, 0 for extended |
| out_len | output | 2 | Instruction length in words (1..3) |
| out_cost | output | 3 | Cycle cost when no conditional test fails |
| out_cost_fail | output | 3 | Cycle cost when the conditional test fails |
| out_is_cond | output | 1 | Instruction is a conditional test |
| out_illegal | output | 1 | Reserved extended opcode |

## Verification
The only state is the output register and its valid bit. A wrong field split or a bad table entry therefore shows up in the one result that carries it, on the cycle right after that word is accepted. A corrupt valid bit or hold path shows up as a dropped, duplicated or changed result during a stall, and it shows on the first cycle where out_ready is low. Because of this, each result is compared with an independently computed expectation when it leaves, and the register is checked for stability on every stalled cycle, with the stall pattern varied.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int OPC_W   = 4;
  localparam int SEL_W   = 6;
  localparam int WORD_W  = 2 * SEL_W + OPC_W;
  localparam int LEN_W   = 2;
  localparam int COST_W  = 3;
  localparam int BASE_W  = 2;
  localparam int NUM_OPS = 2;

  localparam int A_LSB = OPC_W;
  localparam int B_LSB = OPC_W + SEL_W;

  // operand selectors that pull one more word from the stream
  localparam logic [SEL_W-1:0] SEL_IDX_LO = 6'h10;
  localparam logic [SEL_W-1:0] SEL_IDX_HI = 6'h17;
  localparam logic [SEL_W-1:0] SEL_NW_IND = 6'h1e;
  localparam logic [SEL_W-1:0] SEL_NW_LIT = 6'h1f;

  localparam logic [SEL_W-1:0] EXT_CALL = 6'h01;

  typedef enum logic [OPC_W-1:0] {
    OP_EXT  = 4'h0, OP_MOVE = 4'h1, OP_ADD  = 4'h2, OP_SUB  = 4'h3,
    OP_MUL  = 4'h4, OP_DIV  = 4'h5, OP_REM  = 4'h6, OP_SHL  = 4'h7,
    OP_SHR  = 4'h8, OP_AND  = 4'h9, OP_OR   = 4'ha, OP_XOR  = 4'hb,
    OP_TEQ  = 4'hc, OP_TNE  = 4'hd, OP_TGT  = 4'he, OP_TBIT = 4'hf
  } opcode_e;

  typedef struct packed {
    logic              is_ext;
    logic [OPC_W-1:0]  opcode;
    logic [SEL_W-1:0]  ext_op;
    logic [SEL_W-1:0]  sel_a;
    logic [SEL_W-1:0]  sel_b;
    logic [LEN_W-1:0]  len;
    logic [COST_W-1:0] cost;
    logic [COST_W-1:0] cost_fail;
    logic              is_cond;
    logic              illegal;
  } dec_result_t;

  localparam int RESULT_W = $bits(dec_result_t);
endpackage

// File: rtl/ild_operand_words.sv
module ild_operand_words #(
  parameter int SW = ild_pkg::SEL_W
) (
  input  logic [SW-1:0] sel,
  input  logic          present,
  output logic          extra
);
  logic indexed;
  logic next_word;

  always_comb begin
    indexed   = (sel >= ild_pkg::SEL_IDX_LO) && (sel <= ild_pkg::SEL_IDX_HI);
    next_word = (sel == ild_pkg::SEL_NW_IND) || (sel == ild_pkg::SEL_NW_LIT);
    extra     = present && (indexed || next_word);
  end
endmodule

// File: rtl/ild_cost_table.sv
module ild_cost_table
  import ild_pkg::*;
(
  input  logic              is_ext,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [SEL_W-1:0]  ext_op,
  output logic [BASE_W-1:0] base_cost,
  output logic              is_cond,
  output logic              illegal
);
  always_comb begin
    base_cost = 2'd1;
    is_cond   = 1'b0;
    illegal   = 1'b0;
    if (is_ext) begin
      if (ext_op == EXT_CALL) begin
        base_cost = 2'd2;
      end else begin
        base_cost = 2'd1;
        illegal   = 1'b1;
      end
    end else begin
      unique case (opcode_e'(opcode))
        OP_MOVE, OP_AND, OP_OR, OP_XOR:        base_cost = 2'd1;
        OP_ADD, OP_SUB, OP_MUL, OP_SHL, OP_SHR: base_cost = 2'd2;
        OP_DIV, OP_REM:                         base_cost = 2'd3;
        OP_TEQ, OP_TNE, OP_TGT, OP_TBIT: begin
          base_cost = 2'd2;
          is_cond   = 1'b1;
        end
        default:                                base_cost = 2'd1;
      endcase
    end
  end
endmodule

// File: rtl/ild_out_stage.sv
module ild_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         valid_q;
  logic [W-1:0] data_q;
  logic         take;

  assign in_ready  = !valid_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b1;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= in_data;
    end
  end
endmodule

// File: rtl/instr_len_decoder.sv
module instr_len_decoder
  import ild_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_ext,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [SEL_W-1:0]  out_ext_op,
  output logic [SEL_W-1:0]  out_sel_a,
  output logic [SEL_W-1:0]  out_sel_b,
  output logic [LEN_W-1:0]  out_len,
  output logic [COST_W-1:0] out_cost,
  output logic [COST_W-1:0] out_cost_fail,
  output logic              out_is_cond,
  output logic              out_illegal
);
  logic [OPC_W-1:0]  low_op;
  logic [SEL_W-1:0]  mid_field;
  logic [SEL_W-1:0]  top_field;
  logic              ext_form;
  logic [SEL_W-1:0]  op_sel   [NUM_OPS];
  logic              op_there [NUM_OPS];
  logic              op_extra [NUM_OPS];
  logic [BASE_W-1:0] base_cost;
  logic              cond;
  logic              bad_ext;
  logic [LEN_W-1:0]  extra_sum;
  dec_result_t       dec_d;
  dec_result_t       dec_q;

  assign low_op    = in_word[OPC_W-1:0];
  assign mid_field = in_word[A_LSB +: SEL_W];
  assign top_field = in_word[B_LSB +: SEL_W];
  assign ext_form  = (low_op == '0);

  // extended form carries its single operand in the top field
  assign op_sel[0]   = ext_form ? top_field : mid_field;
  assign op_there[0] = 1'b1;
  assign op_sel[1]   = top_field;
  assign op_there[1] = !ext_form;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_operand
    ild_operand_words #(.SW(SEL_W)) u_words (
      .sel     (op_sel[g]),
      .present (op_there[g]),
      .extra   (op_extra[g])
    );
  end

  always_comb begin
    extra_sum = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      extra_sum = extra_sum + LEN_W'(op_extra[i]);
    end
  end

  ild_cost_table u_cost (
    .is_ext    (ext_form),
    .opcode    (low_op),
    .ext_op    (mid_field),
    .base_cost (base_cost),
    .is_cond   (cond),
    .illegal   (bad_ext)
  );

  always_comb begin
    dec_d.is_ext    = ext_form;
    dec_d.opcode    = ext_form ? '0 : low_op;
    dec_d.ext_op    = ext_form ? mid_field : '0;
    dec_d.sel_a     = op_sel[0];
    dec_d.sel_b     = ext_form ? '0 : top_field;
    dec_d.len       = LEN_W'(1) + extra_sum;
    dec_d.cost      = COST_W'(base_cost) + COST_W'(extra_sum);
    dec_d.cost_fail = dec_d.cost + COST_W'(cond);
    dec_d.is_cond   = cond;
    dec_d.illegal   = bad_ext;
  end

  ild_out_stage #(.W(RESULT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (dec_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (dec_q)
  );

  assign out_is_ext    = dec_q.is_ext;
  assign out_opcode    = dec_q.opcode;
  assign out_ext_op    = dec_q.ext_op;
  assign out_sel_a     = dec_q.sel_a;
  assign out_sel_b     = dec_q.sel_b;
  assign out_len       = dec_q.len;
  assign out_cost      = dec_q.cost;
  assign out_cost_fail = dec_q.cost_fail;
  assign out_is_cond   = dec_q.is_cond;
  assign out_illegal   = dec_q.illegal;
endmodule

// File: rtl/ild_checker.sv
module ild_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_is_ext,
  input logic [3:0]  out_opcode,
  input logic [5:0]  out_ext_op,
  input logic [5:0]  out_sel_a,
  input logic [5:0]  out_sel_b,
  input logic [1:0]  out_len,
  input logic [2:0]  out_cost,
  input logic [2:0]  out_cost_fail,
  input logic        out_is_cond,
  input logic        out_illegal
);
  logic [32:0] bundle;
  assign bundle = {out_is_ext, out_opcode, out_ext_op, out_sel_a, out_sel_b,
                   out_len, out_cost, out_cost_fail, out_is_cond, out_illegal};

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(bundle)));

  assert_no_take_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_result_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 2'd1 && out_len <= 2'd3));

  assert_illegal_only_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> out_is_ext);

  assert_cond_basic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_cond) |-> (!out_is_ext && out_opcode[3:2] == 2'b11));

  assert_ext_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_ext) |-> (out_opcode == 4'h0 && out_sel_b == 6'h00
                                   && out_cost_fail == out_cost));
endmodule

bind instr_len_decoder ild_checker u_ild_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_is_ext    (out_is_ext),
  .out_opcode    (out_opcode),
  .out_ext_op    (out_ext_op),
  .out_sel_a     (out_sel_a),
  .out_sel_b     (out_sel_b),
  .out_len       (out_len),
  .out_cost      (out_cost),
  .out_cost_fail (out_cost_fail),
  .out_is_cond   (out_is_cond),
  .out_illegal   (out_illegal)
);

// File: tb/tb_instr_len_decoder.sv
module tb_instr_len_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = 16'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_is_ext;
  logic [3:0]  out_opcode;
  logic [5:0]  out_ext_op;
  logic [5:0]  out_sel_a;
  logic [5:0]  out_sel_b;
  logic [1:0]  out_len;
  logic [2:0]  out_cost;
  logic [2:0]  out_cost_fail;
  logic        out_is_cond;
  logic        out_illegal;

  typedef struct packed {
    logic       is_ext;
    logic [3:0] opcode;
    logic [5:0] ext_op;
    logic [5:0] sel_a;
    logic [5:0] sel_b;
    logic [1:0] len;
    logic [2:0] cost;
    logic [2:0] cost_fail;
    logic       is_cond;
    logic       illegal;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   stall_en = 1'b0;
  bit   sending_done = 1'b0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  instr_len_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_ext(out_is_ext), .out_opcode(out_opcode), .out_ext_op(out_ext_op),
    .out_sel_a(out_sel_a), .out_sel_b(out_sel_b), .out_len(out_len),
    .out_cost(out_cost), .out_cost_fail(out_cost_fail),
    .out_is_cond(out_is_cond), .out_illegal(out_illegal)
  );

  function automatic logic needs_word(input logic [5:0] s);
    return (s[5:3] == 3'b010) || (s == 6'h1e) || (s == 6'h1f);
  endfunction

  function automatic exp_t model(input logic [15:0] w);
    exp_t e;
    logic [2:0] xa;
    logic [2:0] xb;
    logic [2:0] base;
    e = '0;
    if (w[3:0] != 4'h0) begin
      e.opcode = w[3:0];
      e.sel_a  = w[9:4];
      e.sel_b  = w[15:10];
      xa = {2'b0, needs_word(e.sel_a)};
      xb = {2'b0, needs_word(e.sel_b)};
      if (w[3:0] == 4'h5 || w[3:0] == 4'h6) base = 3'd3;
      else if (w[3:0] == 4'h1 || (w[3:0] >= 4'h9 && w[3:0] <= 4'hb)) base = 3'd1;
      else base = 3'd2;
      e.is_cond   = (w[3:0] >= 4'hc);
      e.len       = 2'(3'd1 + xa + xb);
      e.cost      = base + xa + xb;
      e.cost_fail = e.cost + {2'b0, e.is_cond};
    end else begin
      e.is_ext    = 1'b1;
      e.ext_op    = w[9:4];
      e.sel_a     = w[15:10];
      xa = {2'b0, needs_word(e.sel_a)};
      e.illegal   = (w[9:4] != 6'h01);
      base        = e.illegal ? 3'd1 : 3'd2;
      e.len       = 2'(3'd1 + xa);
      e.cost      = base + xa;
      e.cost_fail = e.cost;
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    exp_q.push_back(model(w));
    @(posedge clk);
    #3;
    check("R7 out_valid after accept", {31'b0, out_valid}, 32'd1);
  endtask

  // scoreboard monitor
  initial begin : monitor
    logic [32:0] held;
    bit          was_stalled;
    int          rs;
    exp_t        e;
    logic [32:0] got;
    was_stalled = 1'b0;
    rs = 32'h1ace;
    held = '0;
    forever begin
      @(negedge clk);
      rs = {rs[30:0], rs[31] ^ rs[21] ^ rs[1] ^ rs[0]};
      out_ready = stall_en ? rs[3] : 1'b1;
      #2;
      if (rst_n) begin
        got = {out_is_ext, out_opcode, out_ext_op, out_sel_a, out_sel_b,
               out_len, out_cost, out_cost_fail, out_is_cond, out_illegal};
        check("R8 in_ready rule", {31'b0, in_ready}, {31'b0, (!out_valid || out_ready)});
        if (was_stalled) begin
          check("R8 valid held in stall", {31'b0, out_valid}, 32'd1);
          check("R8 fields held in stall", got[31:0], held[31:0]);
          check("R8 field msb held in stall", {31'b0, got[32]}, {31'b0, held[32]});
        end
        was_stalled = out_valid && !out_ready;
        held = got;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R7 unexpected result", 32'd1, 32'd0);
          end else begin
            e = exp_q.pop_front();
            if (e.is_ext) begin
              check("R2 is_ext", {31'b0, out_is_ext}, 32'd1);
              check("R2 ext_op", {26'b0, out_ext_op}, {26'b0, e.ext_op});
              check("R2 sel_a", {26'b0, out_sel_a}, {26'b0, e.sel_a});
              check("R2 opcode/sel_b zero", {22'b0, out_opcode, out_sel_b}, 32'd0);
              check("R6 illegal", {31'b0, out_illegal}, {31'b0, e.illegal});
              check("R6 cost", {29'b0, out_cost}, {29'b0, e.cost});
            end else begin
              check("R1 is_ext", {31'b0, out_is_ext}, 32'd0);
              check("R1 opcode", {28'b0, out_opcode}, {28'b0, e.opcode});
              check("R1 sel_a", {26'b0, out_sel_a}, {26'b0, e.sel_a});
              check("R1 sel_b", {26'b0, out_sel_b}, {26'b0, e.sel_b});
              check("R1 ext_op zero", {26'b0, out_ext_op}, 32'd0);
              check("R6 basic not illegal", {31'b0, out_illegal}, 32'd0);
              check("R4 cost", {29'b0, out_cost}, {29'b0, e.cost});
            end
            check("R3 len", {30'b0, out_len}, {30'b0, e.len});
            check("R5 is_cond", {31'b0, out_is_cond}, {31'b0, e.is_cond});
            check("R5 cost_fail", {29'b0, out_cost_fail}, {29'b0, e.cost_fail});
          end
        end
      end else begin
        was_stalled = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin : driver
    int r;
    repeat (3) @(negedge clk);
    #2;
    check("R9 out_valid in reset", {31'b0, out_valid}, 32'd0);
    check("R9 in_ready in reset", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corner words
    send(16'h7c01);   // basic, b needs a word: len 2
    send(16'h7de1);   // both operands need a word: len 3
    send(16'h7c10);   // extended call, operand needs a word
    send(16'h0000);   // reserved extended 0x00
    send(16'hc00d);   // conditional
    send(16'h8463);   // short literal: len 1
    send(16'h2161);   // indexed a operand
    send(16'h61c1);   // no extra words
    // every basic opcode with mixed selectors
    for (int op = 1; op < 16; op++) begin
      send({6'h1f, 6'h10, 4'(op)});
      send({6'h3f, 6'h05, 4'(op)});
    end
    // every extended opcode with and without an extra word
    for (int x = 0; x < 64; x++) begin
      send({6'h17, 6'(x), 4'h0});
      send({6'h18, 6'(x), 4'h0});
    end
    // every selector value in both positions
    for (int s = 0; s < 64; s++) begin
      send({6'(s), 6'h00, 4'h2});
      send({6'h00, 6'(s), 4'hc});
    end
    // random words, then again under back-pressure
    r = 32'h5eed1;
    for (int k = 0; k < 600; k++) begin
      if (k == 300) stall_en = 1'b1;
      r = r * 1103515245 + 12345;
      send(r[23:8]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    stall_en = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    sending_done = 1'b1;
    finish_run();
  end
endmodule